// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block decides, for one channel of an asynchronous serial port, how FIFO and receive-path events reach the processor. Each of the two data directions is steered either to a DMA request line or to the shared interrupt line, as a control register selects. Receive errors can raise the interrupt. A clear-to-send (CTS) edge detector can also raise it: it watches for no edge, rising edges, falling edges or both, and sets a sticky status flag that software clears.

Software reaches the block through a small word-addressed bus. Word 0 holds the control fields and word 1 holds the CTS change flag. The FIFO flags come in as levels. The CTS pin is asynchronous and passes through a synchronizer. The interrupt output is a combinational OR of the enabled sources, so it follows the FIFO flags in the same cycle.

Top module: `sio_irq_dma_ctl`

## Requirements
- R1: After reset, word 0 and word 1 read as zero, and both DMA requests and the interrupt line are low.
- R2: Word 0 stores bits 15:9 of a write and reads them back unchanged. All other bits read as zero and ignore writes. The field positions are:
  - bit 15: transmit DMA select
  - bit 14: receive DMA select
  - bit 13: transmit-space interrupt enable
  - bit 12: receive interrupt enable
  - bit 11: error interrupt enable
  - bits 10:9: CTS edge mode
- R3: The transmit DMA request equals transmit DMA select AND transmit FIFO space available.
- R4: The transmit-space interrupt source is active when transmit FIFO space is available, its enable (bit 13) is set and transmit DMA select is clear.
- R5: The receive DMA request equals receive DMA select AND receive data full.
- R6: The receive interrupt source is active when receive data full or receive timeout is set, its enable (bit 12) is set and receive DMA select is clear.
- R7: The error interrupt source is active when frame, parity or overrun error is set and bit 11 is set.
- R8: CTS edge mode 00 detects nothing, 01 detects rising edges, 10 detects falling edges and 11 detects both. A detected edge sets the flag at bit 0 of word 1 on the third rising clock edge after the pin changes.
- R9: The CTS change flag stays set until a write to word 1 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R10: When a detected edge and a clearing write fall in the same cycle, the flag ends up set.
- R11: The interrupt line is the OR of the transmit-space, receive and error sources and the CTS change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Word address (0 control, 1 status) |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| tx_space_i | input | 1 | Transmit FIFO has open space |
| rx_full_i | input | 1 | Receive data full status |
| rx_tout_i | input | 1 | Receive timeout status |
| rx_err_i | input | 3 | Frame, parity and overrun error flags |
| cts_i | input | 1 | Asynchronous CTS pin |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |
| irq_o | output | 1 | Channel interrupt |

## Verification
The routing logic is tried with random control words crossed with random FIFO and error flag levels. This shows whether each event goes to its DMA line or to the interrupt line, and whether a set DMA select masks the matching interrupt source. Directed CTS edges are run in all four modes, with rising and falling pin changes kept apart, so that a mode reacting to the wrong polarity is exposed. Separate sequences place a clearing write alone, together with a fresh edge, and with bit 0 equal to 0. These tell the clear-wins and set-wins priorities apart, and show whether the flag is truly sticky.

// File: rtl/sio_irqd_pkg.sv
package sio_irqd_pkg;

   // CTS edge selection, encoded as stored in the control word
   typedef enum logic [1:0] {
      CTS_OFF  = 2'b00,
      CTS_RISE = 2'b01,
      CTS_FALL = 2'b10,
      CTS_BOTH = 2'b11
   } cts_mode_e;

   // Control fields, packed in the same order as word 0 bits 15:9
   typedef struct packed {
      logic      tx_dma;
      logic      rx_dma;
      logic      tx_ie;
      logic      rx_ie;
      logic      err_ie;
      cts_mode_e cts_mode;
   } ctl_t;

   localparam int unsigned CTL_HI = 15;
   localparam int unsigned CTL_LO = 9;
   localparam int unsigned CTL_W  = CTL_HI - CTL_LO + 1;

endpackage

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
   import sio_irqd_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              flag_i,
   output ctl_t              ctl_o,
   output logic              flag_clr_o,
   output logic [DATA_W-1:0] bus_rdata_o
);

   localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

   if (DATA_W < 16) begin : g_bad_width
      $error("sio_ctl_regs: DATA_W must be at least 16");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sio_ctl_regs: ADDR_W must be at least 1");
   end

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (bus_wr_i && (bus_addr_i == ADDR_CTL)) begin
         ctl_q <= ctl_t'(bus_wdata_i[CTL_HI:CTL_LO]);
      end
   end

   assign ctl_o      = ctl_q;
   assign flag_clr_o = bus_wr_i && (bus_addr_i == ADDR_STAT) && bus_wdata_i[0];

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_CTL) begin
         bus_rdata_o[CTL_HI:CTL_LO] = ctl_q;
      end else if (bus_addr_i == ADDR_STAT) begin
         bus_rdata_o[0] = flag_i;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata_i[DATA_W-1:CTL_HI+1], bus_wdata_i[CTL_LO-1:1]};

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_CTL) |-> (bus_rdata_o[CTL_LO-1:0] == '0));

endmodule

// File: rtl/sio_cts_detect.sv
module sio_cts_detect
   import sio_irqd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cts_i,
   input  cts_mode_e mode_i,
   input  logic      clr_i,
   output logic      hit_o,
   output logic      flag_o
);

   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_cts_detect: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] sync_q;
   logic         prev_q;
   logic         flag_q;
   logic         rise, fall;

   // Synchronizer chain: stage 0 samples the pin
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= cts_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[MSB];
   end

   assign rise = sync_q[MSB] & ~prev_q;
   assign fall = ~sync_q[MSB] & prev_q;

   always_comb begin
      unique case (mode_i)
         CTS_RISE: hit_o = rise;
         CTS_FALL: hit_o = fall;
         CTS_BOTH: hit_o = rise | fall;
         default:  hit_o = 1'b0;
      endcase
   end

   // A new edge wins over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= hit_o | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   // R10
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> flag_o);

   // R8
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == CTS_OFF && !flag_o) |=> !flag_o);

endmodule

// File: rtl/sio_req_route.sv
module sio_req_route
   import sio_irqd_pkg::*;
#(
   parameter int unsigned ERR_W = 3
) (
   input  ctl_t             ctl_i,
   input  logic             tx_space_i,
   input  logic             rx_full_i,
   input  logic             rx_tout_i,
   input  logic [ERR_W-1:0] rx_err_i,
   input  logic             flag_i,
   output logic             tx_dreq_o,
   output logic             rx_dreq_o,
   output logic [3:0]       src_o,
   output logic             irq_o
);

   if (ERR_W < 1) begin : g_bad_err
      $error("sio_req_route: ERR_W must be at least 1");
   end

   assign tx_dreq_o = ctl_i.tx_dma & tx_space_i;
   assign rx_dreq_o = ctl_i.rx_dma & rx_full_i;

   assign src_o[0] = ctl_i.tx_ie  & ~ctl_i.tx_dma & tx_space_i;
   assign src_o[1] = ctl_i.rx_ie  & ~ctl_i.rx_dma & (rx_full_i | rx_tout_i);
   assign src_o[2] = ctl_i.err_ie & (|rx_err_i);
   assign src_o[3] = flag_i;

   assign irq_o = |src_o;

endmodule

// File: rtl/sio_irq_dma_ctl.sv
module sio_irq_dma_ctl
   import sio_irqd_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned ERR_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              tx_space_i,
   input  logic              rx_full_i,
   input  logic              rx_tout_i,
   input  logic [ERR_W-1:0]  rx_err_i,
   input  logic              cts_i,
   output logic              tx_dreq_o,
   output logic              rx_dreq_o,
   output logic              irq_o
);

   ctl_t       ctl;
   logic       flag_clr;
   logic       flag;
   logic       hit;
   logic [3:0] src;

   sio_ctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .flag_i      (flag),
      .ctl_o       (ctl),
      .flag_clr_o  (flag_clr),
      .bus_rdata_o (bus_rdata_o)
   );

   sio_cts_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
      .clk    (clk),
      .rst_n  (rst_n),
      .cts_i  (cts_i),
      .mode_i (ctl.cts_mode),
      .clr_i  (flag_clr),
      .hit_o  (hit),
      .flag_o (flag)
   );

   sio_req_route #(.ERR_W(ERR_W)) u_route (
      .ctl_i      (ctl),
      .tx_space_i (tx_space_i),
      .rx_full_i  (rx_full_i),
      .rx_tout_i  (rx_tout_i),
      .rx_err_i   (rx_err_i),
      .flag_i     (flag),
      .tx_dreq_o  (tx_dreq_o),
      .rx_dreq_o  (rx_dreq_o),
      .src_o      (src),
      .irq_o      (irq_o)
   );

   // R4
   tx_path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_dreq_o && src[0]));

   // R6
   rx_path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_dreq_o && src[1]));

   // R11
   flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> irq_o);

   // R10
   clr_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !hit) |=> !flag);

endmodule

// File: tb/test_sio_irq_dma_ctl.sv
module test_sio_irq_dma_ctl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_space = 1'b0, rx_full = 1'b0, rx_tout = 1'b0, cts = 1'b0;
   logic [2:0]  rx_err = '0;
   logic        tx_dreq, rx_dreq, irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_irq_dma_ctl i_sio_irq_dma_ctl (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tx_space_i(tx_space),
      .rx_full_i(rx_full), .rx_tout_i(rx_tout), .rx_err_i(rx_err), .cts_i(cts),
      .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq), .irq_o(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_readback(logic [31:0] w);
      return w & 32'h0000_FE00;
   endfunction

   function automatic logic exp_irq(logic [31:0] c, logic sp, logic fu, logic to,
                                    logic [2:0] er, logic fl);
      return (c[13] & ~c[15] & sp) | (c[12] & ~c[14] & (fu | to)) | (c[11] & |er) | fl;
   endfunction

   // Called at a negedge; finishes at the next negedge
   task automatic bus_write(logic [1:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] cw;
      void'($urandom(32'd4711));

      // R1 reset state
      wait_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(2'd0, rd); check("R1 ctl", rd, 32'h0);
      bus_read(2'd1, rd); check("R1 stat", rd, 32'h0);
      #1 check("R1 outputs", {tx_dreq, rx_dreq, irq}, 3'b000);

      // R2 readback, directed all-ones and random
      @(negedge clk);
      bus_write(2'd0, 32'hFFFF_FFFF);
      bus_read(2'd0, rd); check("R2 ones", rd, 32'h0000_FE00);
      @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         cw = $urandom;
         bus_write(2'd0, cw);
         bus_read(2'd0, rd); check("R2 random", rd, exp_readback(cw));
         @(negedge clk);
      end

      // R3..R7, R11 routing under random control words and flags (CTS idle)
      for (int i = 0; i < 200; i++) begin
         cw = $urandom & 32'h0000_F800;
         bus_write(2'd0, cw | ($urandom & 32'hFFFF_01FF));
         {tx_space, rx_full, rx_tout} = 3'($urandom);
         rx_err = 3'($urandom);
         #1;
         check("R3 tx_dreq", tx_dreq, cw[15] & tx_space);
         check("R5 rx_dreq", rx_dreq, cw[14] & rx_full);
         check("R4 R6 R7 R11 irq", irq,
               exp_irq(cw, tx_space, rx_full, rx_tout, rx_err, 1'b0));
         @(negedge clk);
      end

      // Directed corners: DMA masks interrupt; timeout alone; each error bit
      {tx_space, rx_full, rx_tout, rx_err} = '0;
      bus_write(2'd0, 32'h0000_A000);
      tx_space = 1'b1; #1;
      check("R4 masked by tx dma", irq, 1'b0);
      check("R3 dma on", tx_dreq, 1'b1);
      @(negedge clk);
      tx_space = 1'b0;
      bus_write(2'd0, 32'h0000_5000);
      rx_tout = 1'b1; #1;
      check("R6 timeout with rx dma", irq, 1'b0);
      check("R5 timeout no dreq", rx_dreq, 1'b0);
      @(negedge clk);
      bus_write(2'd0, 32'h0000_1000); #1;
      check("R6 timeout irq", irq, 1'b1);
      @(negedge clk);
      rx_tout = 1'b0;
      bus_write(2'd0, 32'h0000_0800);
      for (int b = 0; b < 3; b++) begin
         rx_err = 3'(1 << b); #1;
         check("R7 error bit", irq, 1'b1);
         @(negedge clk);
      end
      rx_err = '0;

      // R8 each mode with rising then falling pin changes
      for (int m = 0; m < 4; m++) begin
         bus_write(2'd0, 32'(m) << 9);
         bus_write(2'd1, 32'h1);
         cts = 1'b1;
         wait_cycles(4);
         bus_read(2'd1, rd); check("R8 rise", rd, 32'(m & 1));
         bus_write(2'd1, 32'h1);
         cts = 1'b0;
         wait_cycles(4);
         bus_read(2'd1, rd); check("R8 fall", rd, 32'((m >> 1) & 1));
         bus_write(2'd1, 32'h1);
      end

      // R8 latency: flag appears on the third rising edge after the change
      bus_write(2'd0, 32'h0000_0200);
      cts = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_read(2'd1, rd); check("R8 not before third edge", rd, 32'h0);
      @(negedge clk);
      bus_read(2'd1, rd); check("R8 third edge", rd, 32'h1);

      // R11 flag alone drives irq; R9 write of 0 keeps it
      #1 check("R11 flag irq", irq, 1'b1);
      @(negedge clk);
      bus_write(2'd1, 32'hFFFF_FFFE);
      bus_read(2'd1, rd); check("R9 write zero keeps", rd, 32'h1);
      wait_cycles(3);
      bus_read(2'd1, rd); check("R9 sticky", rd, 32'h1);
      @(negedge clk);
      bus_write(2'd1, 32'h1);
      bus_read(2'd1, rd); check("R9 clear", rd, 32'h0);
      #1 check("R11 irq after clear", irq, 1'b0);

      // R10 edge in the same cycle as a clear: set wins
      @(negedge clk);
      bus_write(2'd0, 32'h0000_0600);
      cts = 1'b0;
      wait_cycles(4);
      bus_read(2'd1, rd); check("R10 preset", rd, 32'h1);
      @(negedge clk);
      cts = 1'b1;
      @(posedge clk); @(negedge clk);  // first sync stage
      @(negedge clk);                 // second stage changed; edge pending
      bus_write(2'd1, 32'h1);         // clear lands with the edge
      bus_read(2'd1, rd); check("R10 edge wins", rd, 32'h1);
      @(negedge clk);
      bus_write(2'd1, 32'h1);
      bus_read(2'd1, rd); check("R10 clear without edge", rd, 32'h0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule